// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block reads a 4x4 key matrix. It pulls one of the four row lines low at a time and reads the four column lines, which pull-ups on the board hold high. When a column reads low while its row is driven, the key at that crossing is closed. A prescaler sets how often the block steps to the next row and how often it samples the columns. Before a key is accepted, its reading has to stay the same across several consecutive samples.

A downstream selection controller gets a 4-bit key code and a strobe that is high for one clock. Each physical press gives one strobe, however long the key is held. A new strobe is possible only after the key has been released and the columns have read high for the debounce interval. The row scan stops on the active row while a press or a release is being qualified, so the same row is sampled for the whole interval. If two columns read low on the same row, the reading is ambiguous and the press is dropped.

Top module: `keypad_scanner`

## Requirements
- R1: During reset and after it is released, `row_n_o` is 1110, `key_valid_o` is 0 and `key_code_o` is 0000.
- R2: With all columns high and no qualification in progress, the row lines step through 1110, 1101, 1011, 0111 and then back to 1110, moving one step per scan tick. Row index r is the row whose bit r is low.
- R3: A scan tick happens every CLK_HZ/SCAN_HZ clock cycles. The row lines change only on a scan tick.
- R4: The row lines stay on the active row while any column reads low or a press or release is being qualified.
- R5: Key (row r, column c) is read as column bit c low while row bit r is driven low. It encodes as follows: column 3 gives 10+r (A=1010, B=1011, C=1100, D=1101). On rows 0 to 2, columns 0 to 2 give the digit 3r+c+1. On row 3, column 0 gives 1110, column 1 gives 0000 and column 2 gives 1111.
- R6: A key is accepted only after DEBOUNCE_TICKS consecutive scan-tick samples read the same row and column pattern. A press that covers fewer samples gives no strobe.
- R7: `key_valid_o` is high for exactly one clock per accepted press, and stays low for the rest of a long hold.
- R8: A new strobe needs the columns to read all high for DEBOUNCE_TICKS consecutive samples first. A shorter release, followed by a press of the same key, gives no second strobe.
- R9: A sample with two or more columns low on the same row is never accepted, and no strobe results from it.
- R10: `key_code_o` changes only in the cycle in which `key_valid_o` is high, and otherwise holds the last accepted code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| col_n_i | input | 4 | Column sense lines, active low, pulled high externally |
| row_n_o | output | 4 | Row drive lines, one driven low at a time |
| key_code_o | output | 4 | Code of the last accepted key |
| key_valid_o | output | 1 | One-clock strobe marking a newly accepted key |

## Verification
Two functions can fall in the same cycle: a scan tick that would move to the next row, and a scan tick on which the debouncer sees a column go low or come back high. The question is whether the row stays put. The bench provokes this by pressing keys on every row at arbitrary scan phases, so a press often lands exactly on the tick where the row would have advanced. It judges the result at the ports: the row lines must stay at the pressed row, the strobe count must be exactly one, and the code must match the arithmetic encoding. It also releases a key for about one tick and presses it again, which causes a release sample and a re-press sample to fall on neighbouring ticks, and it checks that no second strobe comes out.

// File: rtl/kps_pkg.sv
package kps_pkg;

    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int CODE_W = 4;
    localparam int ROW_W = $clog2(ROWS);

    typedef enum logic [1:0] {
        Q_IDLE,
        Q_PRESS,
        Q_HELD,
        Q_RELEASE
    } qual_state_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COLS-1:0]  cols_n;
    } scan_sample_t;

    // number of low columns is exactly one
    function automatic logic single_low(input logic [COLS-1:0] cols_n);
        return $countones(~cols_n) == 1;
    endfunction

    // index of the lowest low column
    function automatic logic [1:0] low_index(input logic [COLS-1:0] cols_n);
        logic [1:0] idx;
        idx = 2'd0;
        for (int i = COLS - 1; i >= 0; i--) begin
            if (!cols_n[i]) idx = 2'(i);
        end
        return idx;
    endfunction

    // key position to code
    function automatic logic [CODE_W-1:0] key_map(input logic [1:0] row,
                                                  input logic [1:0] col);
        logic [CODE_W-1:0] code;
        if (col == 2'd3)
            code = 4'd10 + 4'(row);
        else if (row != 2'd3)
            code = 4'(row) * 4'd3 + 4'(col) + 4'd1;
        else if (col == 2'd0)
            code = 4'd14;
        else if (col == 2'd1)
            code = 4'd0;
        else
            code = 4'd15;
        return code;
    endfunction

endpackage

// File: rtl/kps_prescale.sv
module kps_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt    <= '0;
                    tick_o <= 1'b0;
                end else begin
                    tick_o <= (cnt == CW'(DIV - 2));
                    cnt    <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
                end
            end

            // R3: ticks are separated by at least one idle cycle
            p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end else begin : g_every
            always_ff @(posedge clk) begin
                if (rst) tick_o <= 1'b0;
                else     tick_o <= 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/kps_row_drive.sv
module kps_row_drive
    import kps_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             hold_i,
    output logic [ROW_W-1:0] row_idx_o,
    output logic [ROWS-1:0]  row_n_o
);
    always_ff @(posedge clk) begin
        if (rst)
            row_idx_o <= '0;
        else if (tick_i && !hold_i)
            row_idx_o <= row_idx_o + 1'b1;
    end

    genvar g;
    generate
        for (g = 0; g < ROWS; g++) begin : g_row
            assign row_n_o[g] = (row_idx_o != ROW_W'(g));
        end
    endgenerate

    // R2: walking zero steps one position per free tick
    p_walk_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !hold_i) |=> row_n_o == {$past(row_n_o[ROWS-2:0]), $past(row_n_o[ROWS-1])});

    // R4: rows frozen while held
    p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> $stable(row_n_o));

    // R3: no change without a tick
    p_tick_only_r3: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(row_n_o));

endmodule

// File: rtl/kps_qualify.sv
module kps_qualify
    import kps_pkg::*;
#(
    parameter int DEBOUNCE_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [ROW_W-1:0]  row_idx_i,
    input  logic [COLS-1:0]   cols_n_i,
    output logic              busy_o,
    output logic              valid_o,
    output logic [CODE_W-1:0] code_o
);
    localparam int CW = $clog2(DEBOUNCE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_TICKS - 1);

    qual_state_e  state;
    scan_sample_t cand;
    scan_sample_t sample;
    logic [CW-1:0] cnt;
    logic          all_high;

    assign sample   = '{row: row_idx_i, cols_n: cols_n_i};
    assign all_high = &cols_n_i;
    assign busy_o   = (state != Q_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= Q_IDLE;
            cand    <= '0;
            cnt     <= '0;
            valid_o <= 1'b0;
            code_o  <= '0;
        end else begin
            valid_o <= 1'b0;
            if (tick_i) begin
                unique case (state)
                    Q_IDLE: begin
                        if (!all_high) begin
                            cand  <= sample;
                            cnt   <= CW'(1);
                            state <= Q_PRESS;
                        end
                    end
                    Q_PRESS: begin
                        if (sample == cand) begin
                            if (cnt == LAST) begin
                                state <= Q_HELD;
                                if (single_low(cand.cols_n)) begin
                                    valid_o <= 1'b1;
                                    code_o  <= key_map(cand.row, low_index(cand.cols_n));
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end else if (all_high) begin
                            state <= Q_IDLE;
                        end else begin
                            cand <= sample;
                            cnt  <= CW'(1);
                        end
                    end
                    Q_HELD: begin
                        if (all_high) begin
                            cnt   <= CW'(1);
                            state <= Q_RELEASE;
                        end
                    end
                    Q_RELEASE: begin
                        if (!all_high)
                            state <= Q_HELD;
                        else if (cnt == LAST)
                            state <= Q_IDLE;
                        else
                            cnt <= cnt + 1'b1;
                    end
                    default: state <= Q_IDLE;
                endcase
            end
        end
    end

    // R7: strobe lasts one clock
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R6: acceptance only on a sampling tick
    p_valid_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(tick_i));

    // R10: code moves only with the strobe
    p_code_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_o) |-> valid_o);

    // R9: an accepted sample had exactly one low column
    p_single_r9: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $countones(~$past(cols_n_i)) == 1);

endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
    import kps_pkg::*;
#(
    parameter int CLK_HZ         = 50_000_000,
    parameter int SCAN_HZ        = 1_000,
    parameter int DEBOUNCE_TICKS = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] col_n_i,
    output logic [3:0] row_n_o,
    output logic [3:0] key_code_o,
    output logic       key_valid_o
);
    localparam int DIV = CLK_HZ / SCAN_HZ;

    logic             tick;
    logic             busy;
    logic             hold;
    logic [ROW_W-1:0] row_idx;

    assign hold = busy || !(&col_n_i);

    kps_prescale #(.DIV(DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    kps_row_drive u_rows (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .hold_i    (hold),
        .row_idx_o (row_idx),
        .row_n_o   (row_n_o)
    );

    kps_qualify #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) u_qual (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .row_idx_i (row_idx),
        .cols_n_i  (col_n_i),
        .busy_o    (busy),
        .valid_o   (key_valid_o),
        .code_o    (key_code_o)
    );

    // R1: reset state visible one cycle after a reset cycle
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (row_n_o == 4'b1110 && !key_valid_o && key_code_o == 4'd0));

endmodule

// File: tb/keypad_scanner_test.sv
module keypad_scanner_test;

    localparam int DIV = 4;
    localparam int DB  = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] col_n;
    logic [3:0] row_n;
    logic [3:0] code;
    logic       valid;

    int compared   = 0;
    int mismatched = 0;
    int vcount     = 0;
    int wide_err   = 0;
    logic [3:0] last_code = 4'd0;
    logic       prev_valid = 1'b0;
    longint cyc = 0;

    logic       en [2];
    int         pr [2];
    int         pc [2];

    always #2 clk = ~clk;

    keypad_scanner #(.CLK_HZ(DIV * 1000), .SCAN_HZ(1000), .DEBOUNCE_TICKS(DB)) uut (
        .clk         (clk),
        .rst         (rst),
        .col_n_i     (col_n),
        .row_n_o     (row_n),
        .key_code_o  (code),
        .key_valid_o (valid)
    );

    // matrix model: a closed key ties its column to its row
    always_comb begin
        col_n = 4'hF;
        for (int k = 0; k < 2; k++) begin
            if (en[k] && row_n[pr[k]] == 1'b0) col_n[pc[k]] = 1'b0;
        end
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (valid) begin
            vcount <= vcount + 1;
            last_code <= code;
            if (prev_valid) wide_err <= wide_err + 1;
        end
        prev_valid <= valid;
    end

    function automatic int exp_code(int r, int c);
        if (c == 3) return 10 + r;
        if (r < 3) return r * 3 + c + 1;
        if (c == 0) return 14;
        if (c == 1) return 0;
        return 15;
    endfunction

    task automatic check(string req, longint act, longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(int k, int r, int c);
        @(negedge clk);
        pr[k] = r;
        pc[k] = c;
        en[k] = 1'b1;
    endtask

    task automatic release_all();
        @(negedge clk);
        en[0] = 1'b0;
        en[1] = 1'b0;
    endtask

    task automatic clear_mon();
        @(negedge clk);
        vcount = 0;
        wide_err = 0;
    endtask

    initial begin
        #(200000 * 4);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        en[0] = 1'b0; en[1] = 1'b0;
        pr[0] = 0; pr[1] = 0; pc[0] = 0; pc[1] = 0;
        wait_clk(3);
        // R1 during reset
        check("R1 rows", row_n, 4'b1110);
        check("R1 valid", valid, 0);
        check("R1 code", code, 0);
        @(negedge clk);
        rst = 1'b0;
        check("R1 rows after release", row_n, 4'b1110);

        // R2 / R3: free-running walk and its spacing
        begin
            logic [3:0] prev_rows;
            longint t_prev;
            prev_rows = row_n;
            t_prev = -1;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                while (row_n == prev_rows) @(negedge clk);
                check("R2 order", row_n, {prev_rows[2:0], prev_rows[3]});
                if (t_prev >= 0) check("R3 period", cyc - t_prev, DIV);
                t_prev = cyc;
                prev_rows = row_n;
            end
        end

        // R5 / R7: every key once
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                clear_mon();
                press(0, r, c);
                wait_clk(200);
                release_all();
                wait_clk(100);
                check($sformatf("R7 strobes key r%0d c%0d", r, c), vcount, 1);
                check($sformatf("R5 code key r%0d c%0d", r, c), last_code, exp_code(r, c));
                check("R7 width", wide_err, 0);
            end
        end

        // R4: frozen row while held
        clear_mon();
        press(0, 2, 1);
        wait_clk(60);
        begin
            int moved;
            moved = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (row_n != 4'b1011) moved++;
            end
            check("R4 rows frozen", moved, 0);
        end
        release_all();
        wait_clk(100);
        // R10: code holds after release
        check("R10 code holds", code, exp_code(2, 1));

        // R6: short press ignored
        clear_mon();
        press(0, 1, 1);
        wait_clk(6);
        release_all();
        wait_clk(100);
        check("R6 short press", vcount, 0);
        check("R10 code unchanged", code, exp_code(2, 1));

        // R8: short release then re-press gives no second strobe
        clear_mon();
        press(0, 0, 1);
        wait_clk(100);
        release_all();
        wait_clk(2);
        press(0, 0, 1);
        wait_clk(100);
        release_all();
        wait_clk(100);
        check("R8 bounce on release", vcount, 1);
        press(0, 0, 1);
        wait_clk(100);
        release_all();
        wait_clk(100);
        check("R8 clean re-press", vcount, 2);

        // R9: two columns on one row
        clear_mon();
        press(0, 1, 0);
        press(1, 1, 2);
        wait_clk(150);
        release_all();
        wait_clk(100);
        check("R9 double column", vcount, 0);
        check("R9 code unchanged", code, exp_code(0, 1));
        press(0, 1, 2);
        wait_clk(150);
        release_all();
        wait_clk(100);
        check("R9 single after double", vcount, 1);
        check("R5 code after double", last_code, exp_code(1, 2));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule